// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps a table of memory dependency groups for an out-of-order scheduler model. A group is a set of memory operations that are free of dependences among themselves. For each group the table holds six counters: total predecessors, predecessors that are executing, predecessors that have executed, its own instructions, instructions issued, and instructions finished. It also holds two successor bit vectors, one for order edges and one for data edges. A scheduler feeds one event per cycle on the event port. An event adds an instruction, adds an edge, issues an instruction or finishes an instruction. A separate `tick` input marks the passing of a cycle. The fan-out of an event along the edges of its group completes in the same clock edge.

Each group has a dependency phase: `DEP_WAIT`, `DEP_PEND` or `DEP_READY`. `DEP_WAIT` means some predecessor has not started. `DEP_PEND` means every predecessor has started and at least one is still executing. `DEP_READY` means every predecessor has executed. The phase is decoded with a unique case into the status outputs for the group selected by `q_grp`. The op decoder classifies each event, also with a unique case, as one of four actions: add-instruction, add-edge, issue or finish. It can also classify the event as a no-op or as illegal.

An order edge is released as soon as the producer group has issued all of its outstanding instructions. A data edge is released only when the producer has finished all of them. The block also tracks two latencies. The first is the issued instruction of each group with the most remaining cycles. The second is the largest remaining latency seen on a started data predecessor.

Top module: `mdg_tracker`

## Requirements
- R1: After reset every group has all counters at zero and no edges. It therefore reports ready and executed, and not waiting, pending or executing. Its critical-instruction valid flag is 0, both latency outputs read 0, and `ev_illegal` is 0 for a no-op event.
- R2: Op codes on `ev_op` are 0 no-op, 1 add instruction, 2 add edge (`ev_grp` to `ev_dst`, `ev_data`=1 for a data edge), 3 issue, 4 finish; 5 to 7 act as no-op.
- R3: A group is waiting when its predecessor count exceeds executing plus executed predecessors. It is pending when every predecessor has started and one or more is executing. It is ready when executed predecessors equal predecessors.
- R4: A group is executing when its issued count is nonzero and equals instructions minus finished. It is executed when finished equals instructions. Issue moves one instruction to issued. Finish moves one from issued to finished.
- R5: When a producer becomes executing, each order successor counts that predecessor as executed at once.
- R6: When a producer becomes executing, each data successor counts it as executing. When the producer becomes executed, that count moves from executing to executed.
- R7: Adding an order edge from an executing producer creates no edge and changes nothing. Adding a data edge from an executing producer counts the new predecessor as executing at once.
- R8: A group records the issued instruction with the most remaining cycles (`ev_cyc`, tag `ev_tag`). A smaller or equal value does not replace it. The record is cleared when an instruction with that tag finishes.
- R9: When a data edge's producer starts executing, the successor's critical predecessor latency becomes the larger of its stored value and the producer's critical-instruction cycles. Order edges never change it.
- R10: On each cycle with `tick`=1, a waiting group with a nonzero critical predecessor latency decrements it. A group that is not waiting keeps it.
- R11: Each of the following events raises `ev_illegal` in the same cycle and leaves the table unchanged. Adding an instruction to a group with successors. Issuing to a group that is not ready or has nothing left to issue. Finishing with nothing issued. Adding an edge that is a self edge, a duplicate, from an executed group, or to a group that has already issued or finished instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-cycle time step for critical latency countdown |
| ev_op | input | 3 | Event op code |
| ev_grp | input | GW | Group the event is applied to (edge producer) |
| ev_dst | input | GW | Edge successor group |
| ev_data | input | 1 | Edge kind: 1 data, 0 order |
| ev_cyc | input | CYC_W | Remaining cycles of the issued instruction |
| ev_tag | input | TAG_W | Instruction tag for issue and finish |
| ev_illegal | output | 1 | Current event is illegal and ignored |
| q_grp | input | GW | Group selected for status |
| q_waiting | output | 1 | Selected group waiting |
| q_pending | output | 1 | Selected group pending |
| q_ready | output | 1 | Selected group ready |
| q_executing | output | 1 | Selected group executing |
| q_executed | output | 1 | Selected group executed |
| q_crit_inst_vld | output | 1 | Selected group holds a critical instruction |
| q_crit_inst_cyc | output | CYC_W | Cycles of that critical instruction |
| q_crit_pred_cyc | output | CYC_W | Critical predecessor latency |

## Verification
A vector table first drives a two-instruction producer that has one order successor and one data successor. It records all five status flags for each group after every event. This separates release at full issue from release at full finish, because the two successors diverge between the two finish events. It also separates the two kinds of edge added to an already executing producer, and tells a skipped order edge apart from a data edge that goes straight to pending. Illegal events are mixed into the table, and the status of the target group is read back after each one to show that nothing moved. Directed tests then issue values in increasing, decreasing and larger order to check the critical-instruction record. They also tick a group while it is waiting and again while it is pending, which tells decrementing apart from holding.

// File: rtl/mdg_pkg.sv
package mdg_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ADD_INST = 3'd1,
        OP_ADD_EDGE = 3'd2,
        OP_ISSUE    = 3'd3,
        OP_FINISH   = 3'd4
    } mdg_op_e;

    typedef enum logic [1:0] {
        DEP_WAIT  = 2'd0,
        DEP_PEND  = 2'd1,
        DEP_READY = 2'd2
    } dep_phase_e;

endpackage

// File: rtl/mdg_grp_status.sv
module mdg_grp_status
    import mdg_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] n_pred,
    input  logic [CNT_W-1:0] n_pexing,
    input  logic [CNT_W-1:0] n_pexed,
    input  logic [CNT_W-1:0] n_inst,
    input  logic [CNT_W-1:0] n_iss,
    input  logic [CNT_W-1:0] n_done,
    output logic             waiting,
    output logic             pending,
    output logic             ready,
    output logic             executing,
    output logic             executed
);
    logic [CNT_W:0]   started;
    logic [CNT_W-1:0] left;
    dep_phase_e       phase;

    assign started = {1'b0, n_pexing} + {1'b0, n_pexed};
    assign left    = n_inst - n_done;

    always_comb begin
        if (started < {1'b0, n_pred})
            phase = DEP_WAIT;
        else if (n_pexing != '0)
            phase = DEP_PEND;
        else
            phase = DEP_READY;
    end

    always_comb begin
        waiting = 1'b0;
        pending = 1'b0;
        ready   = 1'b0;
        unique case (phase)
            DEP_WAIT:  waiting = 1'b1;
            DEP_PEND:  pending = 1'b1;
            DEP_READY: ready   = 1'b1;
            default:   waiting = 1'b1;
        endcase
    end

    assign executing = (n_iss != '0) && (n_iss == left);
    assign executed  = (n_done == n_inst);

endmodule

// File: rtl/mdg_event_check.sv
module mdg_event_check
    import mdg_pkg::*;
(
    input  logic [2:0] op,
    input  logic       data,
    input  logic       src_ready,
    input  logic       src_executing,
    input  logic       src_executed,
    input  logic       src_has_succ,
    input  logic       src_inst_full,
    input  logic       src_all_issued,
    input  logic       src_iss_zero,
    input  logic       dst_is_src,
    input  logic       dst_started,
    input  logic       dst_pred_full,
    input  logic       edge_dup,
    output logic       illegal,
    output logic       act_inst,
    output logic       act_edge,
    output logic       act_issue,
    output logic       act_finish
);
    always_comb begin
        illegal    = 1'b0;
        act_inst   = 1'b0;
        act_edge   = 1'b0;
        act_issue  = 1'b0;
        act_finish = 1'b0;
        unique case (op)
            OP_ADD_INST: begin
                if (src_has_succ || src_inst_full) illegal  = 1'b1;
                else                               act_inst = 1'b1;
            end
            OP_ADD_EDGE: begin
                if (dst_is_src || src_executed || edge_dup || dst_started || dst_pred_full)
                    illegal = 1'b1;
                else if (!(src_executing && !data))
                    act_edge = 1'b1;
            end
            OP_ISSUE: begin
                if (!src_ready || src_all_issued) illegal   = 1'b1;
                else                              act_issue = 1'b1;
            end
            OP_FINISH: begin
                if (src_iss_zero) illegal    = 1'b1;
                else              act_finish = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mdg_tracker.sv
module mdg_tracker
    import mdg_pkg::*;
#(
    parameter int NUM_GRP = 8,
    parameter int CNT_W   = 4,
    parameter int CYC_W   = 8,
    parameter int TAG_W   = 4,
    localparam int GW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       ev_op,
    input  logic [GW-1:0]    ev_grp,
    input  logic [GW-1:0]    ev_dst,
    input  logic             ev_data,
    input  logic [CYC_W-1:0] ev_cyc,
    input  logic [TAG_W-1:0] ev_tag,
    output logic             ev_illegal,
    input  logic [GW-1:0]    q_grp,
    output logic             q_waiting,
    output logic             q_pending,
    output logic             q_ready,
    output logic             q_executing,
    output logic             q_executed,
    output logic             q_crit_inst_vld,
    output logic [CYC_W-1:0] q_crit_inst_cyc,
    output logic [CYC_W-1:0] q_crit_pred_cyc
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam logic [CYC_W-1:0] ONE_Y = CYC_W'(1);

    logic [CNT_W-1:0]   pred_a  [NUM_GRP];
    logic [CNT_W-1:0]   pexing_a[NUM_GRP];
    logic [CNT_W-1:0]   pexed_a [NUM_GRP];
    logic [CNT_W-1:0]   inst_a  [NUM_GRP];
    logic [CNT_W-1:0]   iss_a   [NUM_GRP];
    logic [CNT_W-1:0]   done_a  [NUM_GRP];
    logic [NUM_GRP-1:0] osucc_a [NUM_GRP];
    logic [NUM_GRP-1:0] dsucc_a [NUM_GRP];
    logic               civ_a   [NUM_GRP];
    logic [CYC_W-1:0]   cic_a   [NUM_GRP];
    logic [TAG_W-1:0]   cit_a   [NUM_GRP];
    logic [CYC_W-1:0]   cpc_a   [NUM_GRP];

    logic [NUM_GRP-1:0] st_wait, st_pend, st_rdy, st_exing, st_exed;

    // producer-side view of the current event
    logic [CNT_W-1:0] src_iss, src_inst, src_done, src_left, src_iss_inc, src_done_inc;
    logic [CYC_W-1:0] src_cic_nx, src_crit_eff;
    logic             src_becomes_exec, src_becomes_done, edge_live;
    logic             act_inst, act_edge, act_issue, act_finish;

    assign src_iss      = iss_a[ev_grp];
    assign src_inst     = inst_a[ev_grp];
    assign src_done     = done_a[ev_grp];
    assign src_left     = src_inst - src_done;
    assign src_iss_inc  = src_iss + ONE_C;
    assign src_done_inc = src_done + ONE_C;

    mdg_event_check u_chkev (
        .op             (ev_op),
        .data           (ev_data),
        .src_ready      (st_rdy[ev_grp]),
        .src_executing  (st_exing[ev_grp]),
        .src_executed   (st_exed[ev_grp]),
        .src_has_succ   (|{osucc_a[ev_grp], dsucc_a[ev_grp]}),
        .src_inst_full  (&src_inst),
        .src_all_issued (src_iss == src_left),
        .src_iss_zero   (src_iss == '0),
        .dst_is_src     (ev_dst == ev_grp),
        .dst_started    ((iss_a[ev_dst] != '0) || (done_a[ev_dst] != '0)),
        .dst_pred_full  (&pred_a[ev_dst]),
        .edge_dup       (osucc_a[ev_grp][ev_dst] || dsucc_a[ev_grp][ev_dst]),
        .illegal        (ev_illegal),
        .act_inst       (act_inst),
        .act_edge       (act_edge),
        .act_issue      (act_issue),
        .act_finish     (act_finish)
    );

    assign src_becomes_exec = act_issue  && (src_iss_inc == src_left);
    assign src_becomes_done = act_finish && (src_done_inc == src_inst);
    assign src_cic_nx   = (!civ_a[ev_grp] || (cic_a[ev_grp] < ev_cyc)) ? ev_cyc : cic_a[ev_grp];
    assign src_crit_eff = civ_a[ev_grp] ? cic_a[ev_grp] : '0;
    assign edge_live    = act_edge && st_exing[ev_grp];

    for (genvar s = 0; s < NUM_GRP; s++) begin : g_grp
        logic [CNT_W-1:0]   pred_r, pexing_r, pexed_r, inst_r, iss_r, done_r;
        logic [CNT_W-1:0]   pred_n, pexing_n, pexed_n, inst_n, iss_n, done_n;
        logic [NUM_GRP-1:0] osucc_r, dsucc_r, osucc_n, dsucc_n;
        logic               civ_r, civ_n;
        logic [CYC_W-1:0]   cic_r, cic_n, cpc_r, cpc_n;
        logic [TAG_W-1:0]   cit_r, cit_n;
        logic               hit_src, hit_dst, is_os, is_ds;

        assign hit_src = (ev_grp == GW'(s));
        assign hit_dst = (ev_dst == GW'(s));
        assign is_os   = osucc_a[ev_grp][s];
        assign is_ds   = dsucc_a[ev_grp][s];

        mdg_grp_status #(.CNT_W(CNT_W)) u_st (
            .n_pred    (pred_r),
            .n_pexing  (pexing_r),
            .n_pexed   (pexed_r),
            .n_inst    (inst_r),
            .n_iss     (iss_r),
            .n_done    (done_r),
            .waiting   (st_wait[s]),
            .pending   (st_pend[s]),
            .ready     (st_rdy[s]),
            .executing (st_exing[s]),
            .executed  (st_exed[s])
        );

        always_comb begin
            pred_n   = pred_r;
            pexing_n = pexing_r;
            pexed_n  = pexed_r;
            inst_n   = inst_r;
            iss_n    = iss_r;
            done_n   = done_r;
            osucc_n  = osucc_r;
            dsucc_n  = dsucc_r;
            civ_n    = civ_r;
            cic_n    = cic_r;
            cit_n    = cit_r;
            cpc_n    = (tick && st_wait[s] && (cpc_r != '0)) ? cpc_r - ONE_Y : cpc_r;
            // own-group updates
            if (hit_src) begin
                if (act_inst) inst_n = inst_r + ONE_C;
                if (act_edge) begin
                    if (ev_data) dsucc_n[ev_dst] = 1'b1;
                    else         osucc_n[ev_dst] = 1'b1;
                end
                if (act_issue) begin
                    iss_n = iss_r + ONE_C;
                    if (!civ_r || (cic_r < ev_cyc)) begin
                        civ_n = 1'b1;
                        cic_n = ev_cyc;
                        cit_n = ev_tag;
                    end
                end
                if (act_finish) begin
                    iss_n  = iss_r - ONE_C;
                    done_n = done_r + ONE_C;
                    if (civ_r && (cit_r == ev_tag)) begin
                        civ_n = 1'b0;
                        cic_n = '0;
                    end
                end
            end
            // successor-side updates
            if (act_edge && hit_dst) begin
                pred_n = pred_r + ONE_C;
                if (edge_live) begin
                    pexing_n = pexing_r + ONE_C;
                    if (src_crit_eff > cpc_n) cpc_n = src_crit_eff;
                end
            end
            if (src_becomes_exec && is_os) pexed_n = pexed_r + ONE_C;
            if (src_becomes_exec && is_ds) begin
                pexing_n = pexing_r + ONE_C;
                if (src_cic_nx > cpc_n) cpc_n = src_cic_nx;
            end
            if (src_becomes_done && is_ds) begin
                pexing_n = pexing_r - ONE_C;
                pexed_n  = pexed_r + ONE_C;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pred_r   <= '0;
                pexing_r <= '0;
                pexed_r  <= '0;
                inst_r   <= '0;
                iss_r    <= '0;
                done_r   <= '0;
                osucc_r  <= '0;
                dsucc_r  <= '0;
                civ_r    <= 1'b0;
                cic_r    <= '0;
                cit_r    <= '0;
                cpc_r    <= '0;
            end else begin
                pred_r   <= pred_n;
                pexing_r <= pexing_n;
                pexed_r  <= pexed_n;
                inst_r   <= inst_n;
                iss_r    <= iss_n;
                done_r   <= done_n;
                osucc_r  <= osucc_n;
                dsucc_r  <= dsucc_n;
                civ_r    <= civ_n;
                cic_r    <= cic_n;
                cit_r    <= cit_n;
                cpc_r    <= cpc_n;
            end
        end

        assign pred_a[s]   = pred_r;
        assign pexing_a[s] = pexing_r;
        assign pexed_a[s]  = pexed_r;
        assign inst_a[s]   = inst_r;
        assign iss_a[s]    = iss_r;
        assign done_a[s]   = done_r;
        assign osucc_a[s]  = osucc_r;
        assign dsucc_a[s]  = dsucc_r;
        assign civ_a[s]    = civ_r;
        assign cic_a[s]    = cic_r;
        assign cit_a[s]    = cit_r;
        assign cpc_a[s]    = cpc_r;
    end

    assign q_waiting       = st_wait[q_grp];
    assign q_pending       = st_pend[q_grp];
    assign q_ready         = st_rdy[q_grp];
    assign q_executing     = st_exing[q_grp];
    assign q_executed      = st_exed[q_grp];
    assign q_crit_inst_vld = civ_a[q_grp];
    assign q_crit_inst_cyc = cic_a[q_grp];
    assign q_crit_pred_cyc = cpc_a[q_grp];

endmodule

// File: rtl/mdg_tracker_chk.sv
module mdg_tracker_chk #(
    parameter int GW    = 3,
    parameter int CYC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [2:0]       ev_op,
    input logic [GW-1:0]    ev_grp,
    input logic             ev_illegal,
    input logic [GW-1:0]    q_grp,
    input logic             q_waiting,
    input logic             q_pending,
    input logic             q_ready,
    input logic             q_executing,
    input logic             q_executed,
    input logic             q_crit_inst_vld,
    input logic [CYC_W-1:0] q_crit_inst_cyc,
    input logic [CYC_W-1:0] q_crit_pred_cyc
);
    AST_READY_NOT_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |-> !q_waiting); // R3

    AST_PENDING_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        q_pending |-> (!q_waiting && !q_ready)); // R3

    AST_EXECUTING_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        q_executing |-> !q_executed); // R4

    AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_illegal && (q_grp == ev_grp)) |=>
        (!$stable(q_grp) || $stable({q_waiting, q_pending, q_ready, q_executing,
                                     q_executed, q_crit_inst_vld, q_crit_inst_cyc}))); // R11

    AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (ev_op == 3'd0) && q_waiting && (q_crit_pred_cyc != '0)) |=>
        (!$stable(q_grp) || (q_crit_pred_cyc == $past(q_crit_pred_cyc) - CYC_W'(1)))); // R10

    AST_NOP_NEVER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_op == 3'd0) |-> !ev_illegal); // R2
endmodule

bind mdg_tracker mdg_tracker_chk #(.GW(GW), .CYC_W(CYC_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick            (tick),
    .ev_op           (ev_op),
    .ev_grp          (ev_grp),
    .ev_illegal      (ev_illegal),
    .q_grp           (q_grp),
    .q_waiting       (q_waiting),
    .q_pending       (q_pending),
    .q_ready         (q_ready),
    .q_executing     (q_executing),
    .q_executed      (q_executed),
    .q_crit_inst_vld (q_crit_inst_vld),
    .q_crit_inst_cyc (q_crit_inst_cyc),
    .q_crit_pred_cyc (q_crit_pred_cyc)
);

// File: tb/mdg_tracker_tb.sv
`timescale 1ns/1ps
module mdg_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] ev_op = 3'd0;
    logic [2:0] ev_grp = '0, ev_dst = '0, q_grp = '0;
    logic       ev_data = 1'b0;
    logic [7:0] ev_cyc = '0;
    logic [3:0] ev_tag = '0;
    logic       ev_illegal;
    logic       q_waiting, q_pending, q_ready, q_executing, q_executed, q_crit_inst_vld;
    logic [7:0] q_crit_inst_cyc, q_crit_pred_cyc;

    int cnt_chk = 0;
    int cnt_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mdg_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ev_op(ev_op), .ev_grp(ev_grp),
        .ev_dst(ev_dst), .ev_data(ev_data), .ev_cyc(ev_cyc), .ev_tag(ev_tag),
        .ev_illegal(ev_illegal), .q_grp(q_grp), .q_waiting(q_waiting),
        .q_pending(q_pending), .q_ready(q_ready), .q_executing(q_executing),
        .q_executed(q_executed), .q_crit_inst_vld(q_crit_inst_vld),
        .q_crit_inst_cyc(q_crit_inst_cyc), .q_crit_pred_cyc(q_crit_pred_cyc)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] g;
        logic [2:0] d;
        logic       dat;
        logic [7:0] cyc;
        logic [3:0] tag;
        logic [2:0] qg;
        logic       err;
        logic [4:0] st;   // {waiting, pending, ready, executing, executed}
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd0, 1'b0, 5'b00100}, // R4 add inst
        '{3'd1, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd0, 1'b0, 5'b00100}, // R4
        '{3'd1, 3'd1, 3'd0, 1'b0, 8'd0, 4'd0, 3'd1, 1'b0, 5'b00100}, // R4
        '{3'd1, 3'd2, 3'd0, 1'b0, 8'd0, 4'd0, 3'd2, 1'b0, 5'b00100}, // R4
        '{3'd2, 3'd0, 3'd1, 1'b0, 8'd0, 4'd0, 3'd1, 1'b0, 5'b10000}, // R3 order edge waits
        '{3'd2, 3'd0, 3'd2, 1'b1, 8'd0, 4'd0, 3'd2, 1'b0, 5'b10000}, // R3 data edge waits
        '{3'd1, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd0, 1'b1, 5'b00100}, // R11 inst after succ
        '{3'd3, 3'd1, 3'd0, 1'b0, 8'd5, 4'd0, 3'd1, 1'b1, 5'b10000}, // R11 issue not ready
        '{3'd3, 3'd0, 3'd0, 1'b0, 8'd3, 4'd1, 3'd0, 1'b0, 5'b00100}, // R4 partial issue
        '{3'd3, 3'd0, 3'd0, 1'b0, 8'd7, 4'd2, 3'd0, 1'b0, 5'b00110}, // R4 executing
        '{3'd0, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd1, 1'b0, 5'b00100}, // R5 order released
        '{3'd0, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd2, 1'b0, 5'b01000}, // R6 data pending
        '{3'd3, 3'd0, 3'd0, 1'b0, 8'd1, 4'd3, 3'd0, 1'b1, 5'b00110}, // R11 issue executing
        '{3'd2, 3'd0, 3'd3, 1'b0, 8'd0, 4'd0, 3'd3, 1'b0, 5'b00101}, // R7 order skipped
        '{3'd2, 3'd0, 3'd3, 1'b1, 8'd0, 4'd0, 3'd3, 1'b0, 5'b01001}, // R7 data live
        '{3'd4, 3'd0, 3'd0, 1'b0, 8'd0, 4'd2, 3'd0, 1'b0, 5'b00110}, // R4 one finished
        '{3'd0, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd2, 1'b0, 5'b01000}, // R6 still pending
        '{3'd4, 3'd0, 3'd0, 1'b0, 8'd0, 4'd1, 3'd0, 1'b0, 5'b00101}, // R4 executed
        '{3'd0, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd2, 1'b0, 5'b00100}, // R6 data released
        '{3'd0, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd3, 1'b0, 5'b00101}, // R7 late data released
        '{3'd4, 3'd0, 3'd0, 1'b0, 8'd0, 4'd0, 3'd0, 1'b1, 5'b00101}, // R11 finish none
        '{3'd2, 3'd0, 3'd1, 1'b0, 8'd0, 4'd0, 3'd1, 1'b1, 5'b00100}, // R11 edge from executed
        '{3'd2, 3'd1, 3'd1, 1'b0, 8'd0, 4'd0, 3'd1, 1'b1, 5'b00100}, // R11 self edge
        '{3'd3, 3'd1, 3'd0, 1'b0, 8'd2, 4'd3, 3'd1, 1'b0, 5'b00110}, // R4
        '{3'd4, 3'd1, 3'd0, 1'b0, 8'd0, 4'd3, 3'd1, 1'b0, 5'b00101}  // R4
    };

    task automatic check(input string req, input int act, input int exp);
        cnt_chk++;
        if (act != exp) begin
            cnt_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one event at a falling edge; returns at the next falling edge with a no-op
    task automatic do_ev(input logic [2:0] op, input logic [2:0] g, input logic [2:0] d,
                         input logic dat, input logic [7:0] cyc, input logic [3:0] tag);
        @(negedge clk);
        ev_op = op; ev_grp = g; ev_dst = d; ev_data = dat; ev_cyc = cyc; ev_tag = tag;
        @(negedge clk);
        ev_op = 3'd0;
    endtask

    function automatic logic [4:0] stat();
        return {q_waiting, q_pending, q_ready, q_executing, q_executed};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ev_op = 3'd0; tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state of every group
        for (int i = 0; i < 8; i++) begin
            q_grp = 3'(i);
            #1;
            check($sformatf("R1 status grp%0d", i), int'(stat()), 5'b00101);
            check($sformatf("R1 crit grp%0d", i),
                  int'({q_crit_inst_vld, q_crit_inst_cyc, q_crit_pred_cyc}), 0);
        end
        check("R1 no-op legal", int'(ev_illegal), 0);

        // R2 R3 R4 R5 R6 R7 R11 vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ev_op = VEC[i].op; ev_grp = VEC[i].g; ev_dst = VEC[i].d;
            ev_data = VEC[i].dat; ev_cyc = VEC[i].cyc; ev_tag = VEC[i].tag;
            #1;
            check($sformatf("R11/R2 illegal row %0d", i), int'(ev_illegal), int'(VEC[i].err));
            @(negedge clk);
            ev_op = 3'd0; q_grp = VEC[i].qg;
            #1;
            check($sformatf("R3/R4/R5/R6/R7 status row %0d", i), int'(stat()), int'(VEC[i].st));
        end

        // R2: reserved op code is a no-op
        do_ev(3'd6, 3'd5, 3'd6, 1'b1, 8'd9, 4'd1);
        q_grp = 3'd5; #1;
        check("R2 reserved op no effect", int'(stat()), 5'b00101);

        // R8: critical instruction record
        do_reset();
        do_ev(3'd1, 3'd4, 3'd0, 1'b0, 8'd0, 4'd0);
        do_ev(3'd1, 3'd4, 3'd0, 1'b0, 8'd0, 4'd0);
        do_ev(3'd1, 3'd4, 3'd0, 1'b0, 8'd0, 4'd0);
        do_ev(3'd3, 3'd4, 3'd0, 1'b0, 8'd4, 4'd5);
        q_grp = 3'd4; #1;
        check("R8 first issue recorded", int'({q_crit_inst_vld, q_crit_inst_cyc}), {1'b1, 8'd4});
        do_ev(3'd3, 3'd4, 3'd0, 1'b0, 8'd2, 4'd6);
        #1;
        check("R8 smaller keeps", int'({q_crit_inst_vld, q_crit_inst_cyc}), {1'b1, 8'd4});
        do_ev(3'd3, 3'd4, 3'd0, 1'b0, 8'd9, 4'd7);
        #1;
        check("R8 larger replaces", int'({q_crit_inst_vld, q_crit_inst_cyc}), {1'b1, 8'd9});
        do_ev(3'd4, 3'd4, 3'd0, 1'b0, 8'd0, 4'd6);
        #1;
        check("R8 other tag keeps", int'({q_crit_inst_vld, q_crit_inst_cyc}), {1'b1, 8'd9});
        do_ev(3'd4, 3'd4, 3'd0, 1'b0, 8'd0, 4'd7);
        #1;
        check("R8 matching tag clears", int'(q_crit_inst_vld), 0);

        // R9 R10: critical predecessor latency and tick
        do_reset();
        for (int g = 0; g < 4; g++) do_ev(3'd1, 3'(g), 3'd0, 1'b0, 8'd0, 4'd0);
        do_ev(3'd2, 3'd0, 3'd1, 1'b1, 8'd0, 4'd0);
        do_ev(3'd2, 3'd2, 3'd1, 1'b1, 8'd0, 4'd0);
        do_ev(3'd2, 3'd0, 3'd3, 1'b0, 8'd0, 4'd0);
        do_ev(3'd3, 3'd0, 3'd0, 1'b0, 8'd6, 4'd1);
        q_grp = 3'd1; #1;
        check("R9 data successor takes latency", int'(q_crit_pred_cyc), 6);
        check("R3 one of two started waits", int'(stat()), 5'b10000);
        q_grp = 3'd3; #1;
        check("R9 order successor unchanged", int'(q_crit_pred_cyc), 0);
        check("R5 order successor ready", int'(stat()), 5'b00100);
        @(negedge clk); tick = 1'b1;
        @(negedge clk);
        @(negedge clk); tick = 1'b0;
        q_grp = 3'd1; #1;
        check("R10 waiting decrements", int'(q_crit_pred_cyc), 4);
        do_ev(3'd3, 3'd2, 3'd0, 1'b0, 8'd3, 4'd2);
        #1;
        check("R9 smaller keeps max", int'(q_crit_pred_cyc), 4);
        check("R3 all started pending", int'(stat()), 5'b01000);
        @(negedge clk); tick = 1'b1;
        @(negedge clk);
        @(negedge clk); tick = 1'b0;
        #1;
        check("R10 pending holds", int'(q_crit_pred_cyc), 4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", cnt_chk, cnt_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            cnt_chk++;
            cnt_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", cnt_chk, cnt_fail);
            $finish;
        end
    end
endmodule